// File: doc/BRIEF.md
# Two-Level Shared Interrupt Aggregator for a Removable-Card Storage Host

This block collects the interrupt events of a removable-card storage host controller into a per-source status register. Each source bit has its own enable. A second, global level is shared with a neighbouring controller. At that level the card controller owns one bit and the neighbour owns another. Each global bit can be masked separately from being latched (status-enable) and from reaching the output line (signal-enable). The block drives a single interrupt line.

The block also watches the two active-low card-detect pins. It resynchronises them, decides whether a card is fully seated, keeps a card-present flag, and raises the card-detect source event whenever that seated state changes. Software reaches every register through a simple word-addressed write port and a combinational read port. Status bits at both levels are cleared by writing ones.

Top module: `cfirq_aggregator`

## Requirements
- R1: After reset every status, enable and mask register reads zero, the interrupt output is low and the card-present flag is low.
- R2: Source status bits sit at fixed positions: bit 0 card detect, bit 1 status change, bit 2 memory mode, bit 3 I/O mode, bit 8 true-IDE, bit 9 PIO transfer error, bit 10 buffer available, bit 11 transfer done. A one-cycle pulse on `src_evt_i[n]` sets status bit n for n in {1,2,3,8,9,10,11}. Bits 4 to 7 never set and read 0. `src_evt_i[0]` has no effect, because bit 0 is set only by the card-detect logic.
- R3: Writing to the source status register (address 0) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: When an event arrives in the same cycle as a clearing write to the same bit, the bit stays set.
- R5: The source enable register (address 1) is separate from status and reads back what was written, restricted to the implemented bits {0,1,2,3,8,9,10,11}.
- R6: Global status bit 0 (address 2) latches one cycle after some source bit is both set and enabled, but only while global status-enable bit 0 (address 3) is 1. It stays set after the source is cleared, until bit 0 is written with 1 to address 2. A clearing write while a source is still pending and enabled leaves the bit set.
- R7: Global status bit 1 latches on a `sib_evt_i` pulse while global status-enable bit 1 is 1, and is cleared by writing 1 to bit 1 of address 2.
- R8: `irq_o` is high exactly when some global status bit is 1 and the matching global signal-enable bit (address 4) is 1.
- R9: Each card-detect pin passes through two synchroniser flops. A card counts as seated only when both pins are low. Three clock edges after a change of the seated state at the pins, `card_present_o` follows that state and source status bit 0 sets, for insertion and for removal alike.
- R10: Addresses 5 to 7 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 12 | Register write data |
| reg_rdata_o | output | 12 | Register read data (combinational from address) |
| src_evt_i | input | 12 | One-cycle source event pulses, indexed by status bit position |
| sib_evt_i | input | 1 | Event pulse from the neighbouring controller |
| card_det_ni | input | 2 | Active-low card-detect pins |
| irq_o | output | 1 | Shared interrupt output |
| card_present_o | output | 1 | Card fully seated flag |

## Verification
The hardest case to reach from the ports is the race between an event and a clearing write to the same bit, together with the global re-latch while a source is still pending. The bench reaches the race by pulsing an event in the very cycle that carries the clearing write. It reaches the re-latch by clearing the global bit while an enabled source bit is left set. It also sweeps every combination of the two global masks with the source enable on and off, and predicts the latched bits and the line from those masks. Card detection is driven through insertion, partial seating and removal, and the flag is sampled on the edge before the expected change as well as on the edge of the change.

// File: rtl/cfirq_pkg.sv
package cfirq_pkg;

    localparam int SRC_W = 12;
    localparam int GLB_W = 2;

    localparam int BIT_CARD_DET = 0;
    localparam int BIT_STS_CHG  = 1;
    localparam int BIT_MEM_MODE = 2;
    localparam int BIT_IO_MODE  = 3;
    localparam int BIT_IDE_MODE = 8;
    localparam int BIT_PIO_ERR  = 9;
    localparam int BIT_BUF_AVL  = 10;
    localparam int BIT_XFER_END = 11;

    localparam logic [SRC_W-1:0] CD_MASK = SRC_W'(1) << BIT_CARD_DET;

    localparam logic [SRC_W-1:0] SRC_IMPL =
        (SRC_W'(1) << BIT_CARD_DET) | (SRC_W'(1) << BIT_STS_CHG) |
        (SRC_W'(1) << BIT_MEM_MODE) | (SRC_W'(1) << BIT_IO_MODE) |
        (SRC_W'(1) << BIT_IDE_MODE) | (SRC_W'(1) << BIT_PIO_ERR) |
        (SRC_W'(1) << BIT_BUF_AVL)  | (SRC_W'(1) << BIT_XFER_END);

    localparam int GLB_CARD = 0;
    localparam int GLB_SIB  = 1;

    typedef enum logic [2:0] {
        REG_SRC_STS  = 3'd0,
        REG_SRC_EN   = 3'd1,
        REG_GLB_STS  = 3'd2,
        REG_GLB_STEN = 3'd3,
        REG_GLB_SGEN = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic [SRC_W-1:0] sts;
        logic [SRC_W-1:0] en;
    } src_regs_t;

    typedef struct packed {
        logic [GLB_W-1:0] sts;
        logic [GLB_W-1:0] sten;
        logic [GLB_W-1:0] sgen;
    } glb_regs_t;

endpackage

// File: rtl/cfirq_card_detect.sv
module cfirq_card_detect #(
    parameter int SYNC_STAGES = 2,
    parameter int PIN_W       = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [PIN_W-1:0] pins_ni,
    output logic             present_o,
    output logic             change_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0][PIN_W-1:0] chain;
        logic                              present;
    } cd_regs_t;

    cd_regs_t r_d, r_q;
    logic     seated_now;

    always_comb begin
        r_d          = r_q;
        r_d.chain[0] = pins_ni;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            r_d.chain[i] = r_q.chain[i-1];
        end
        seated_now  = ~|r_q.chain[SYNC_STAGES-1];
        change_o    = seated_now != r_q.present;
        r_d.present = seated_now;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.chain   <= '1;
            r_q.present <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign present_o = r_q.present;

endmodule

// File: rtl/cfirq_src_level.sv
module cfirq_src_level
    import cfirq_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SRC_W-1:0] ext_evt_i,
    input  logic             cd_evt_i,
    input  logic             clr_wr_i,
    input  logic             en_wr_i,
    input  logic [SRC_W-1:0] wdata_i,
    output logic [SRC_W-1:0] sts_o,
    output logic [SRC_W-1:0] en_o,
    output logic             pending_o
);

    src_regs_t        r_d, r_q;
    logic [SRC_W-1:0] set_v;
    logic [SRC_W-1:0] clr_v;

    always_comb begin
        r_d   = r_q;
        set_v = (ext_evt_i & SRC_IMPL & ~CD_MASK) | (cd_evt_i ? CD_MASK : '0);
        clr_v = clr_wr_i ? wdata_i : '0;
        // a new event overrides a simultaneous clear of the same bit
        r_d.sts = (r_q.sts & ~clr_v) | set_v;
        if (en_wr_i) begin
            r_d.en = wdata_i & SRC_IMPL;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sts_o     = r_q.sts;
    assign en_o      = r_q.en;
    assign pending_o = |(r_q.sts & r_q.en);

endmodule

// File: rtl/cfirq_glb_level.sv
module cfirq_glb_level
    import cfirq_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             card_pend_i,
    input  logic             sib_evt_i,
    input  logic             clr_wr_i,
    input  logic             sten_wr_i,
    input  logic             sgen_wr_i,
    input  logic [GLB_W-1:0] wdata_i,
    output logic [GLB_W-1:0] sts_o,
    output logic [GLB_W-1:0] sten_o,
    output logic [GLB_W-1:0] sgen_o,
    output logic             irq_o
);

    glb_regs_t        r_d, r_q;
    logic [GLB_W-1:0] raw_v;
    logic [GLB_W-1:0] set_v;
    logic [GLB_W-1:0] clr_v;

    always_comb begin
        r_d             = r_q;
        raw_v           = '0;
        raw_v[GLB_CARD] = card_pend_i;
        raw_v[GLB_SIB]  = sib_evt_i;
        set_v           = raw_v & r_q.sten;
        clr_v           = clr_wr_i ? wdata_i : '0;
        r_d.sts         = (r_q.sts & ~clr_v) | set_v;
        if (sten_wr_i) begin
            r_d.sten = wdata_i;
        end
        if (sgen_wr_i) begin
            r_d.sgen = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sts_o  = r_q.sts;
    assign sten_o = r_q.sten;
    assign sgen_o = r_q.sgen;
    assign irq_o  = |(r_q.sts & r_q.sgen);

endmodule

// File: rtl/cfirq_aggregator.sv
module cfirq_aggregator
    import cfirq_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic [SRC_W-1:0]  src_evt_i,
    input  logic              sib_evt_i,
    input  logic [1:0]        card_det_ni,
    output logic              irq_o,
    output logic              card_present_o
);

    logic             cd_change;
    logic             src_pending;
    logic [SRC_W-1:0] src_sts, src_en;
    logic [GLB_W-1:0] glb_sts, glb_sten, glb_sgen;
    logic             wr_src_sts, wr_src_en, wr_glb_sts, wr_glb_sten, wr_glb_sgen;

    always_comb begin
        wr_src_sts  = reg_wr_i && (reg_addr_i == ADDR_W'(REG_SRC_STS));
        wr_src_en   = reg_wr_i && (reg_addr_i == ADDR_W'(REG_SRC_EN));
        wr_glb_sts  = reg_wr_i && (reg_addr_i == ADDR_W'(REG_GLB_STS));
        wr_glb_sten = reg_wr_i && (reg_addr_i == ADDR_W'(REG_GLB_STEN));
        wr_glb_sgen = reg_wr_i && (reg_addr_i == ADDR_W'(REG_GLB_SGEN));
    end

    cfirq_card_detect #(
        .SYNC_STAGES (SYNC_STAGES),
        .PIN_W       (2)
    ) u_cd (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pins_ni   (card_det_ni),
        .present_o (card_present_o),
        .change_o  (cd_change)
    );

    cfirq_src_level u_src (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ext_evt_i (src_evt_i),
        .cd_evt_i  (cd_change),
        .clr_wr_i  (wr_src_sts),
        .en_wr_i   (wr_src_en),
        .wdata_i   (reg_wdata_i[SRC_W-1:0]),
        .sts_o     (src_sts),
        .en_o      (src_en),
        .pending_o (src_pending)
    );

    cfirq_glb_level u_glb (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .card_pend_i (src_pending),
        .sib_evt_i   (sib_evt_i),
        .clr_wr_i    (wr_glb_sts),
        .sten_wr_i   (wr_glb_sten),
        .sgen_wr_i   (wr_glb_sgen),
        .wdata_i     (reg_wdata_i[GLB_W-1:0]),
        .sts_o       (glb_sts),
        .sten_o      (glb_sten),
        .sgen_o      (glb_sgen),
        .irq_o       (irq_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            ADDR_W'(REG_SRC_STS):  reg_rdata_o = DATA_W'(src_sts);
            ADDR_W'(REG_SRC_EN):   reg_rdata_o = DATA_W'(src_en);
            ADDR_W'(REG_GLB_STS):  reg_rdata_o = DATA_W'(glb_sts);
            ADDR_W'(REG_GLB_STEN): reg_rdata_o = DATA_W'(glb_sten);
            ADDR_W'(REG_GLB_SGEN): reg_rdata_o = DATA_W'(glb_sgen);
            default:               reg_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/cfirq_checker.sv
module cfirq_checker
    import cfirq_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             reg_wr_i,
    input logic [2:0]       reg_addr_i,
    input logic [SRC_W-1:0] reg_wdata_i,
    input logic [SRC_W-1:0] src_evt_i,
    input logic             sib_evt_i,
    input logic [SRC_W-1:0] src_sts,
    input logic [SRC_W-1:0] src_en,
    input logic [GLB_W-1:0] glb_sts,
    input logic [GLB_W-1:0] glb_sten,
    input logic [GLB_W-1:0] glb_sgen,
    input logic             irq_o,
    input logic             card_present_o
);

    localparam logic [SRC_W-1:0] EXT_MASK = SRC_IMPL & ~CD_MASK;

    // R2: unimplemented positions never hold state
    p_unimpl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((src_sts & ~SRC_IMPL) == '0) && ((src_en & ~SRC_IMPL) == '0));

    // R3: bits written with one and not re-raised are clear afterwards
    p_w1c_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && reg_addr_i == 3'd0) |=>
        ((src_sts & $past(reg_wdata_i) & ~$past(src_evt_i) & ~CD_MASK) == '0));

    // R4: an incoming event is always captured, even under a clear
    p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((src_evt_i & EXT_MASK) != '0) |=>
        ((src_sts & $past(src_evt_i & EXT_MASK)) == $past(src_evt_i & EXT_MASK)));

    // R6: enabled pending source latches the card global bit
    p_glb_latch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((|(src_sts & src_en)) && glb_sten[GLB_CARD]) |=> glb_sts[GLB_CARD]);

    // R7: neighbour event latches the shared bit when enabled
    p_sib_latch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sib_evt_i && glb_sten[GLB_SIB]) |=> glb_sts[GLB_SIB]);

    // R8: the line needs a latched and signal-enabled global bit
    p_irq_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> ((glb_sts & glb_sgen) != '0));

    // R9: every change of the present flag raises the card-detect bit
    p_cd_event_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (card_present_o != $past(card_present_o)) |-> src_sts[BIT_CARD_DET]);

endmodule

bind cfirq_aggregator cfirq_checker u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .reg_wr_i       (reg_wr_i),
    .reg_addr_i     (reg_addr_i),
    .reg_wdata_i    (reg_wdata_i),
    .src_evt_i      (src_evt_i),
    .sib_evt_i      (sib_evt_i),
    .src_sts        (src_sts),
    .src_en         (src_en),
    .glb_sts        (glb_sts),
    .glb_sten       (glb_sten),
    .glb_sgen       (glb_sgen),
    .irq_o          (irq_o),
    .card_present_o (card_present_o)
);

// File: tb/tb_cfirq_aggregator.sv
module tb_cfirq_aggregator;

    localparam int CLK_NS = 20;
    localparam logic [11:0] IMPL = 12'hF0F;
    localparam logic [11:0] EXT  = 12'hF0E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [2:0]  addr = '0;
    logic [11:0] wdata = '0;
    logic [11:0] rdata;
    logic [11:0] evt = '0;
    logic        sib = 1'b0;
    logic [1:0]  cd_n = 2'b11;
    logic        irq;
    logic        present;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    cfirq_aggregator dut (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .reg_wr_i       (wr),
        .reg_addr_i     (addr),
        .reg_wdata_i    (wdata),
        .reg_rdata_o    (rdata),
        .src_evt_i      (evt),
        .sib_evt_i      (sib),
        .card_det_ni    (cd_n),
        .irq_o          (irq),
        .card_present_o (present)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [11:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output int v);
        addr = a;
        #1;
        v = int'(rdata);
    endtask

    task automatic clear_all();
        wr_reg(3'd1, 12'h000);
        wr_reg(3'd3, 12'h000);
        wr_reg(3'd4, 12'h000);
        wr_reg(3'd0, 12'hFFF);
        wr_reg(3'd2, 12'h003);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd_reg(3'(a), v);
            check("R1 reg after reset", v, 0);
        end
        check("R1 irq after reset", int'(irq), 0);
        check("R1 present after reset", int'(present), 0);

        // R2: single-bit event sweep over every input position
        for (int b = 0; b < 12; b++) begin
            evt = 12'(1 << b);
            @(negedge clk);
            evt = '0;
            rd_reg(3'd0, v);
            check("R2 event position", v, int'(12'(1 << b) & EXT));
            wr_reg(3'd0, 12'hFFF);
        end

        // R5: enable register readback over write patterns
        for (int p = 0; p < 16; p++) begin
            logic [11:0] pat;
            pat = {p[3:0], p[3:0] ^ 4'hA, p[3:0]};
            wr_reg(3'd1, pat);
            rd_reg(3'd1, v);
            check("R5 enable readback", v, int'(pat & IMPL));
        end
        wr_reg(3'd1, 12'h000);

        // R3: write-one-to-clear, zeros keep bits
        evt = 12'hFFF;
        @(negedge clk);
        evt = '0;
        wr_reg(3'd0, 12'h000);
        rd_reg(3'd0, v);
        check("R3 zero write keeps", v, int'(EXT));
        wr_reg(3'd0, 12'h00A);
        rd_reg(3'd0, v);
        check("R3 partial clear", v, int'(EXT & ~12'h00A));
        wr_reg(3'd0, 12'hFFF);
        rd_reg(3'd0, v);
        check("R3 full clear", v, 0);

        // R4: event and clear collide on bit 9, bit 10 clears normally
        evt = 12'h600;
        @(negedge clk);
        evt = '0;
        wr = 1'b1; addr = 3'd0; wdata = 12'h600; evt = 12'h200;
        @(negedge clk);
        wr = 1'b0; wdata = '0; evt = '0;
        rd_reg(3'd0, v);
        check("R4 set wins over clear", v, 32'h200);
        wr_reg(3'd0, 12'hFFF);

        // R6 R7 R8: sweep global masks and source enable
        for (int ge = 0; ge < 4; ge++) begin
            for (int se = 0; se < 4; se++) begin
                for (int k = 0; k < 2; k++) begin
                    int eg;
                    clear_all();
                    wr_reg(3'd1, (k != 0) ? 12'h400 : 12'h000);
                    wr_reg(3'd3, 12'(ge));
                    wr_reg(3'd4, 12'(se));
                    evt = 12'h400; sib = 1'b1;
                    @(negedge clk);
                    evt = '0; sib = 1'b0;
                    @(negedge clk);
                    eg = ((ge >> 1) & 1) * 2 + ((ge & 1) & k);
                    rd_reg(3'd2, v);
                    check("R6 R7 global latch", v, eg);
                    check("R8 irq line", int'(irq), ((eg & se) != 0) ? 1 : 0);
                end
            end
        end

        // R6: persistence after source clear, and re-latch while pending
        clear_all();
        wr_reg(3'd1, 12'h800);
        wr_reg(3'd3, 12'h001);
        wr_reg(3'd4, 12'h001);
        evt = 12'h800;
        @(negedge clk);
        evt = '0;
        @(negedge clk);
        wr_reg(3'd2, 12'h001);
        rd_reg(3'd2, v);
        check("R6 clear while pending re-latches", v, 1);
        wr_reg(3'd0, 12'hFFF);
        rd_reg(3'd2, v);
        check("R6 stays after source clear", v, 1);
        check("R8 irq held", int'(irq), 1);
        wr_reg(3'd2, 12'h001);
        rd_reg(3'd2, v);
        check("R6 cleared by write", v, 0);
        check("R8 irq drops", int'(irq), 0);

        // R9: insertion, partial seating, removal
        clear_all();
        cd_n = 2'b00;
        @(negedge clk);
        @(negedge clk);
        check("R9 not yet present", int'(present), 0);
        @(negedge clk);
        check("R9 present after insert", int'(present), 1);
        rd_reg(3'd0, v);
        check("R9 detect bit on insert", v, 1);
        wr_reg(3'd0, 12'h001);
        cd_n = 2'b01;
        @(negedge clk);
        @(negedge clk);
        check("R9 still present before change", int'(present), 1);
        @(negedge clk);
        check("R9 one pin high is not seated", int'(present), 0);
        rd_reg(3'd0, v);
        check("R9 detect bit on removal", v, 1);
        wr_reg(3'd0, 12'h001);
        cd_n = 2'b11;
        repeat (4) @(negedge clk);
        rd_reg(3'd0, v);
        check("R9 no event without seated change", v, 0);

        // R10: unmapped addresses
        wr_reg(3'd1, 12'h00F);
        for (int a = 5; a < 8; a++) begin
            wr_reg(3'(a), 12'hFFF);
            rd_reg(3'(a), v);
            check("R10 unmapped reads zero", v, 0);
        end
        rd_reg(3'd1, v);
        check("R10 mapped register untouched", v, 32'h00F);
        rd_reg(3'd4, v);
        check("R10 signal enable untouched", v, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule